// File: doc/BRIEF.md
# PATA PIO Host Cycle Engine

This block sits between a CPU register port and a parallel ATA bus. It runs programmed-I/O cycles to a single CompactFlash card operating in True IDE mode. Software programs a control word, a configuration word and a packed timing word. Each write to an address in the bus window then launches one write cycle on the ATA bus, using the taskfile or data register that matches that address.

Reads are posted. A CPU read of a bus-window address returns zero and starts a bus read cycle. The engine captures the device's value at the end of the strobe phase. Software then fetches that value from a separate read-data register.

A busy nibble in the status word tells software when the engine is free to accept the next access. An interrupt status word records three events: completed reads, device interrupt edges and rejected accesses. Each event can be masked before it reaches the interrupt output.

Top module: `pio_host_engine`

## Requirements
- R1: After reset, both chip selects and both strobes are high and the data bus is not driven. The interrupt output is low, and the control, status and interrupt-status words read as zero.
- R2: A cycle spends max(S,1) clocks in setup with the address valid and both strobes high. It then spends max(A,1) clocks with the strobe low, followed by max(R,1) clocks in recovery. S, A and R are timing-word bits [3:0], [11:4] and [19:12] at offset 0x2.
- R3: A write to the bus window drives the latched data onto the bus and asserts the data-bus enable from setup through recovery. It pulses the write strobe low in the active phase, and the read strobe stays high.
- R4: A read of the bus window returns zero on the register port and runs a read cycle with the read strobe low. The value on the data bus at the last active clock is then readable at offset 0x6. That value holds until the next read cycle completes.
- R5: With configuration bit 1 set, the active phase lasts as long as IORDY is sampled low after the programmed count has expired. With bit 1 clear, IORDY has no effect.
- R6: With configuration bit 6 set, the two bytes of a 16-bit word are exchanged in both directions for the data register (offset 0x10). The 8-bit taskfile registers are unaffected.
- R7: While control bit 0 is clear, a bus-window access starts no cycle, leaves the busy nibble at zero and sets no error bit.
- R8: Status-word bits [31:28] read 0xF from the clock after an access is accepted until the cycle returns to idle, and 0x0 otherwise.
- R9: A bus-window access that arrives while a cycle is running is dropped, not queued, and it sets interrupt-status bit 2. The running cycle completes unchanged.
- R10: Interrupt-status bit 0 is set by a completed read and bit 1 by a rising edge on the device interrupt line. Writing 1 clears a bit (offset 0x4). The interrupt output is the OR of the status bits ANDed with the mask at offset 0x5.
- R11: Addresses 0x10-0x17 select chip select 0 (cs_n = 2'b10) and 0x18-0x1F select chip select 1 (cs_n = 2'b01), with the device address equal to address bits [2:0]. Every register except 0x10 is 8 bits wide: a write drives the upper byte as zero, and a read keeps only the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register port word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data (combinational) |
| irq | output | 1 | Masked interrupt request |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Active-low read strobe |
| ata_diow_n | output | 1 | Active-low write strobe |
| ata_dd_out | output | DATA_W | Data bus, outbound |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | DATA_W | Data bus, inbound |
| ata_iordy | input | 1 | Device ready, stretches the strobe |
| ata_intrq | input | 1 | Device interrupt request |

## Verification
A sequencer counter that is off by one shows up within a single cycle as a wrong number of clocks with the strobe low or the chip select active. The bench therefore counts each phase at the pins for several timing words, including all-zero. A capture or hold error in the read path appears at the next fetch of the read-data register, and a lost busy flag appears as a second bus cycle where the bench expects a rejection. Interrupt state is read back through the status word and the irq pin immediately after each event or clearing write.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_t;

   localparam logic [3:0] OFF_CTRL   = 4'h0;
   localparam logic [3:0] OFF_CFG    = 4'h1;
   localparam logic [3:0] OFF_TIMING = 4'h2;
   localparam logic [3:0] OFF_STATUS = 4'h3;
   localparam logic [3:0] OFF_ISTAT  = 4'h4;
   localparam logic [3:0] OFF_IMASK  = 4'h5;
   localparam logic [3:0] OFF_RDATA  = 4'h6;

   localparam int CFG_IORDY_BIT = 1;
   localparam int CFG_SWAP_BIT  = 6;

   localparam int NIRQ    = 3;
   localparam int IRQ_RD  = 0;
   localparam int IRQ_DEV = 1;
   localparam int IRQ_REJ = 2;

   localparam logic [3:0] BUSY_NIB = 4'hF;
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
   import pio_pkg::*;
#(
   parameter int REG_DW = 32,
   parameter int TIM_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_off,
   input  logic [REG_DW-1:0] wdata,
   input  logic [NIRQ-1:0]   ev_set,
   output logic              enable,
   output logic              iordy_en,
   output logic              swap_en,
   output logic [TIM_W-1:0]  timing,
   output logic [NIRQ-1:0]   irq_stat,
   output logic [NIRQ-1:0]   irq_mask,
   output logic              irq
);
   generate
      if (TIM_W > REG_DW) begin : g_bad_tim
         $error("timing word wider than register port");
      end
      if (REG_DW <= CFG_SWAP_BIT) begin : g_bad_dw
         $error("register port too narrow for configuration bits");
      end
   endgenerate

   logic [NIRQ-1:0] clr_bits;
   logic            unused_wdata;

   assign unused_wdata = ^wdata;
   assign clr_bits = (wr_en && wr_off == OFF_ISTAT) ? wdata[NIRQ-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         iordy_en <= 1'b0;
         swap_en  <= 1'b0;
         timing   <= '0;
         irq_mask <= '0;
         irq_stat <= '0;
      end else begin
         if (wr_en) begin
            unique case (wr_off)
               OFF_CTRL:   enable <= wdata[0];
               OFF_CFG: begin
                  iordy_en <= wdata[CFG_IORDY_BIT];
                  swap_en  <= wdata[CFG_SWAP_BIT];
               end
               OFF_TIMING: timing   <= wdata[TIM_W-1:0];
               OFF_IMASK:  irq_mask <= wdata[NIRQ-1:0];
               default: ;
            endcase
         end
         irq_stat <= (irq_stat & ~clr_bits) | ev_set;
      end
   end

   assign irq = |(irq_stat & irq_mask);

   a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == OFF_ISTAT && wdata[IRQ_RD] && !ev_set[IRQ_RD]) |=> !irq_stat[IRQ_RD]);
   a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[IRQ_DEV] |=> irq_stat[IRQ_DEV]);
endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
   import pio_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_setup,
   input  logic [CNT_W-1:0] len_active,
   input  logic [CNT_W-1:0] len_recov,
   input  logic             iordy_en,
   input  logic             iordy,
   output phase_t           phase,
   output logic             cap_en
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("counter width must be positive");
      end
   endgenerate

   phase_t           ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_zero, hold_ok;

   function automatic logic [CNT_W-1:0] first_count(input logic [CNT_W-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   assign cnt_zero = (cnt_q == '0);
   assign hold_ok  = !iordy_en || iordy;

   always_comb begin
      ph_d   = ph_q;
      cnt_d  = cnt_zero ? cnt_q : cnt_q - 1'b1;
      cap_en = 1'b0;
      unique case (ph_q)
         PH_IDLE: if (start) begin
            ph_d  = PH_SETUP;
            cnt_d = first_count(len_setup);
         end
         PH_SETUP: if (cnt_zero) begin
            ph_d  = PH_ACTIVE;
            cnt_d = first_count(len_active);
         end
         PH_ACTIVE: if (cnt_zero && hold_ok) begin
            ph_d   = PH_RECOV;
            cnt_d  = first_count(len_recov);
            cap_en = 1'b1;
         end
         PH_RECOV: if (cnt_zero) ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   assign phase = ph_q;

   a_r5_iordy_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_ACTIVE && iordy_en && !iordy) |=> ph_q == PH_ACTIVE);
   a_r7_idle_without_start: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && !start) |=> ph_q == PH_IDLE);
   a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && start) |=> ph_q == PH_SETUP);
endmodule

// File: rtl/pio_bus_if.sv
module pio_bus_if
   import pio_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              acc_wr,
   input  logic              acc_cs1,
   input  logic [2:0]        acc_da,
   input  logic              acc_data,
   input  logic [DATA_W-1:0] wdata,
   input  logic              swap_en,
   input  phase_t            phase,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] dd_in,
   output logic [1:0]        cs_n,
   output logic [2:0]        da,
   output logic              dior_n,
   output logic              diow_n,
   output logic [DATA_W-1:0] dd_out,
   output logic              dd_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_done
);
   localparam int HALF = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_w
         $error("data bus width must be even");
      end
   endgenerate

   logic              wr_q, cs1_q, data_q;
   logic [2:0]        da_q;
   logic [DATA_W-1:0] wbuf_q, rdata_q;
   logic [DATA_W-1:0] wr_view, rd_view;
   logic              busy;

   generate
      if (SWAP_SUPPORT) begin : g_swap
         assign wr_view = (swap_en && acc_data) ? {wdata[HALF-1:0], wdata[DATA_W-1:HALF]} : wdata;
         assign rd_view = (swap_en && data_q)   ? {dd_in[HALF-1:0], dd_in[DATA_W-1:HALF]} : dd_in;
      end else begin : g_noswap
         logic unused_swap;
         assign unused_swap = swap_en;
         assign wr_view = wdata;
         assign rd_view = dd_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         cs1_q   <= 1'b0;
         data_q  <= 1'b0;
         da_q    <= '0;
         wbuf_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (start) begin
            wr_q   <= acc_wr;
            cs1_q  <= acc_cs1;
            data_q <= acc_data;
            da_q   <= acc_da;
            wbuf_q <= acc_data ? wr_view : {{HALF{1'b0}}, wdata[HALF-1:0]};
         end
         if (cap_en && !wr_q)
            rdata_q <= data_q ? rd_view : {{HALF{1'b0}}, dd_in[HALF-1:0]};
      end
   end

   assign busy    = (phase != PH_IDLE);
   assign cs_n    = !busy ? 2'b11 : (cs1_q ? 2'b01 : 2'b10);
   assign da      = da_q;
   assign dior_n  = !(phase == PH_ACTIVE && !wr_q);
   assign diow_n  = !(phase == PH_ACTIVE && wr_q);
   assign dd_out  = wbuf_q;
   assign dd_oe   = busy && wr_q;
   assign rdata   = rdata_q;
   assign rd_done = cap_en && !wr_q;

   a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_en && !wr_q) |=> $stable(rdata_q));
   a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (phase == PH_IDLE || ($stable(cs_n) && $stable(da))));
endmodule

// File: rtl/pio_host_engine.sv
module pio_host_engine
   import pio_pkg::*;
#(
   parameter int REG_AW       = 5,
   parameter int REG_DW       = 32,
   parameter int DATA_W       = 16,
   parameter int TIM_SW       = 4,
   parameter int TIM_AW       = 8,
   parameter int TIM_RW       = 8,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              irq,
   output logic [1:0]        ata_cs_n,
   output logic [2:0]        ata_da,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   output logic [DATA_W-1:0] ata_dd_out,
   output logic              ata_dd_oe,
   input  logic [DATA_W-1:0] ata_dd_in,
   input  logic              ata_iordy,
   input  logic              ata_intrq
);
   localparam int TIM_W = TIM_SW + TIM_AW + TIM_RW;
   localparam int CNT_A = (TIM_SW > TIM_AW) ? TIM_SW : TIM_AW;
   localparam int CNT_W = (CNT_A > TIM_RW) ? CNT_A : TIM_RW;
   localparam logic [REG_AW-1:0] BUS_BASE = REG_AW'(16);

   generate
      if (REG_AW < 5) begin : g_bad_aw
         $error("register address needs at least five bits");
      end
      if (REG_DW < DATA_W || REG_DW < TIM_W || REG_DW < 8) begin : g_bad_rdw
         $error("register port narrower than a field it carries");
      end
   endgenerate

   logic              ctl_hit, bus_hit, bus_acc, busy, start, reject;
   logic              enable, iordy_en, swap_en, irq_w;
   logic [TIM_W-1:0]  timing;
   logic [NIRQ-1:0]   irq_stat, irq_mask, ev_set;
   logic              intrq_q, rd_done, cap_en;
   logic [DATA_W-1:0] rdata;
   phase_t            phase;

   assign ctl_hit = (reg_addr[REG_AW-1:4] == '0);
   assign bus_hit = (reg_addr[REG_AW-1:4] == BUS_BASE[REG_AW-1:4]);
   assign bus_acc = bus_hit && (reg_wr || reg_rd);
   assign busy    = (phase != PH_IDLE);
   assign start   = bus_acc && enable && !busy;
   assign reject  = bus_acc && enable && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) intrq_q <= 1'b0;
      else        intrq_q <= ata_intrq;
   end

   always_comb begin
      ev_set          = '0;
      ev_set[IRQ_RD]  = rd_done;
      ev_set[IRQ_DEV] = ata_intrq && !intrq_q;
      ev_set[IRQ_REJ] = reject;
   end

   pio_regfile #(.REG_DW(REG_DW), .TIM_W(TIM_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr && ctl_hit),
      .wr_off   (reg_addr[3:0]),
      .wdata    (reg_wdata),
      .ev_set   (ev_set),
      .enable   (enable),
      .iordy_en (iordy_en),
      .swap_en  (swap_en),
      .timing   (timing),
      .irq_stat (irq_stat),
      .irq_mask (irq_mask),
      .irq      (irq_w)
   );

   pio_cycle_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .len_setup  (CNT_W'(timing[TIM_SW-1:0])),
      .len_active (CNT_W'(timing[TIM_SW+TIM_AW-1:TIM_SW])),
      .len_recov  (CNT_W'(timing[TIM_W-1:TIM_SW+TIM_AW])),
      .iordy_en   (iordy_en),
      .iordy      (ata_iordy),
      .phase      (phase),
      .cap_en     (cap_en)
   );

   pio_bus_if #(.DATA_W(DATA_W), .SWAP_SUPPORT(SWAP_SUPPORT)) i_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .acc_wr   (reg_wr),
      .acc_cs1  (reg_addr[3]),
      .acc_da   (reg_addr[2:0]),
      .acc_data (reg_addr[3:0] == 4'h0),
      .wdata    (reg_wdata[DATA_W-1:0]),
      .swap_en  (swap_en),
      .phase    (phase),
      .cap_en   (cap_en),
      .dd_in    (ata_dd_in),
      .cs_n     (ata_cs_n),
      .da       (ata_da),
      .dior_n   (ata_dior_n),
      .diow_n   (ata_diow_n),
      .dd_out   (ata_dd_out),
      .dd_oe    (ata_dd_oe),
      .rdata    (rdata),
      .rd_done  (rd_done)
   );

   always_comb begin
      reg_rdata = '0;
      if (ctl_hit) begin
         unique case (reg_addr[3:0])
            OFF_CTRL:   reg_rdata[0] = enable;
            OFF_CFG: begin
               reg_rdata[CFG_IORDY_BIT] = iordy_en;
               reg_rdata[CFG_SWAP_BIT]  = swap_en;
            end
            OFF_TIMING: reg_rdata[TIM_W-1:0]    = timing;
            OFF_STATUS: reg_rdata[REG_DW-1 -: 4] = busy ? BUSY_NIB : 4'h0;
            OFF_ISTAT:  reg_rdata[NIRQ-1:0]     = irq_stat;
            OFF_IMASK:  reg_rdata[NIRQ-1:0]     = irq_mask;
            OFF_RDATA:  reg_rdata[DATA_W-1:0]   = rdata;
            default: ;
         endcase
      end
   end

   assign irq = irq_w;

   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ata_dior_n || ata_diow_n);
   a_r9_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> irq_stat[IRQ_REJ]);
   a_r8_busy_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (ata_cs_n != 2'b11));
   a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !busy) |=> ata_cs_n == 2'b11);
endmodule

// File: tb/test_pio_host_engine.sv
module test_pio_host_engine;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int XW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   wire  [DW-1:0] reg_rdata;
   wire           irq;
   wire  [1:0]    ata_cs_n;
   wire  [2:0]    ata_da;
   wire           ata_dior_n, ata_diow_n, ata_dd_oe;
   wire  [XW-1:0] ata_dd_out;
   logic [XW-1:0] dev_data = '0;
   logic          ata_iordy = 1'b1;
   logic          ata_intrq = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   pio_host_engine i_pio_host_engine (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .ata_cs_n(ata_cs_n),
      .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
      .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(dev_data),
      .ata_iordy(ata_iordy), .ata_intrq(ata_intrq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // Called at the negedge following the accepting edge; walks the cycle at the pins.
   task automatic measure(input int rel, output int s, output int a, output int r,
                          output logic [1:0] cs, output logic [2:0] da,
                          output logic [15:0] dout, output logic wstr);
      int guard = 0;
      s = 0; a = 0; r = 0; cs = ata_cs_n; da = ata_da; dout = '0; wstr = 1'b0;
      while (ata_cs_n != 2'b11 && guard < 2000) begin
         if (!ata_dior_n || !ata_diow_n) begin
            a++;
            dout = ata_dd_out;
            wstr = !ata_diow_n;
            if (rel > 0 && a == rel) ata_iordy = 1'b1;
         end else if (a == 0) s++;
         else r++;
         guard++;
         @(negedge clk);
      end
   endtask

   int s, a, r;
   logic [1:0]    cs;
   logic [2:0]    da;
   logic [15:0]   dout;
   logic          wstr;
   logic [DW-1:0] v;

   task automatic t_reset();
      check("R1 cs_n", {30'd0, ata_cs_n}, 32'd3);
      check("R1 strobes", {30'd0, ata_dior_n, ata_diow_n}, 32'd3);
      check("R1 oe", {31'd0, ata_dd_oe}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(5'h03, v); check("R1 status", v, 32'd0);
      rd(5'h00, v); check("R1 ctrl", v, 32'd0);
      rd(5'h04, v); check("R1 istat", v, 32'd0);
   endtask

   task automatic t_write();
      wr(5'h13, 32'hABCD);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R2 setup", s, 2); check("R2 active", a, 3); check("R2 recovery", r, 1);
      check("R11 cs0", {30'd0, cs}, 32'd2); check("R11 da", {29'd0, da}, 32'd3);
      check("R11 byte write", {16'd0, dout}, 32'h00CD);
      check("R3 write strobe", {31'd0, wstr}, 32'd1);
   endtask

   task automatic t_timing();
      wr(5'h02, 32'h0);
      wr(5'h10, 32'h5555);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R2 zero setup", s, 1); check("R2 zero active", a, 1); check("R2 zero recovery", r, 1);
      check("R3 data word", {16'd0, dout}, 32'h5555);
      wr(5'h02, 32'h06045);
      wr(5'h12, 32'h11);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R2 setup 5", s, 5); check("R2 active 4", a, 4); check("R2 recovery 6", r, 6);
      wr(5'h02, 32'h01032);
   endtask

   task automatic t_read();
      dev_data = 16'h1234;
      rd(5'h10, v);
      check("R4 posted read returns zero", v, 32'd0);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R4 read strobe active", a, 3);
      check("R4 no write strobe", {31'd0, wstr}, 32'd0);
      rd(5'h06, v); check("R4 read data", v, 32'h1234);
      rd(5'h04, v); check("R10 read done bit", v, 32'd1);
      dev_data = 16'h9999;
      repeat (4) @(negedge clk);
      rd(5'h06, v); check("R4 read data held", v, 32'h1234);
      dev_data = 16'h5AA5;
      rd(5'h1F, v);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R11 cs1", {30'd0, cs}, 32'd1); check("R11 da 7", {29'd0, da}, 32'd7);
      rd(5'h06, v); check("R11 byte read", v, 32'h00A5);
   endtask

   task automatic t_reject();
      wr(5'h04, 32'h7);
      rd(5'h04, v); check("R10 w1c all", v, 32'd0);
      wr(5'h12, 32'h77);
      rd(5'h03, v); check("R8 busy nibble", v, 32'hF000_0000);
      wr(5'h13, 32'h88);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R9 original data", {16'd0, dout}, 32'h0077);
      check("R9 original da", {29'd0, da}, 32'd2);
      rd(5'h03, v); check("R8 idle nibble", v, 32'd0);
      rd(5'h04, v); check("R9 reject bit", v, 32'd4);
      repeat (5) @(negedge clk);
      check("R9 nothing queued", {30'd0, ata_cs_n}, 32'd3);
      wr(5'h04, 32'h4);
      rd(5'h04, v); check("R10 w1c reject", v, 32'd0);
   endtask

   task automatic t_irq();
      wr(5'h05, 32'h0);
      ata_intrq = 1'b1;
      repeat (2) @(negedge clk);
      rd(5'h04, v); check("R10 intrq edge", v, 32'd2);
      check("R10 masked irq", {31'd0, irq}, 32'd0);
      wr(5'h05, 32'h2);
      check("R10 unmasked irq", {31'd0, irq}, 32'd1);
      wr(5'h04, 32'h2);
      check("R10 irq cleared, level no edge", {31'd0, irq}, 32'd0);
      ata_intrq = 1'b0;
      wr(5'h05, 32'h0);
   endtask

   task automatic t_iordy();
      wr(5'h01, 32'h2);
      ata_iordy = 1'b0;
      wr(5'h11, 32'h42);
      measure(7, s, a, r, cs, da, dout, wstr);
      check("R5 stretched active", a, 7);
      check("R5 setup unchanged", s, 2);
      wr(5'h01, 32'h0);
      ata_iordy = 1'b0;
      wr(5'h11, 32'h43);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R5 iordy ignored", a, 3);
      ata_iordy = 1'b1;
   endtask

   task automatic t_swap();
      wr(5'h01, 32'h40);
      wr(5'h10, 32'h1234);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R6 swapped write", {16'd0, dout}, 32'h3412);
      dev_data = 16'hBEEF;
      rd(5'h10, v);
      measure(0, s, a, r, cs, da, dout, wstr);
      rd(5'h06, v); check("R6 swapped read", v, 32'hEFBE);
      wr(5'h11, 32'hC3);
      measure(0, s, a, r, cs, da, dout, wstr);
      check("R6 taskfile write unswapped", {16'd0, dout}, 32'h00C3);
      dev_data = 16'h12C3;
      rd(5'h11, v);
      measure(0, s, a, r, cs, da, dout, wstr);
      rd(5'h06, v); check("R6 taskfile read unswapped", v, 32'h00C3);
      wr(5'h01, 32'h0);
   endtask

   task automatic t_disable();
      int act_cycles = 0;
      wr(5'h04, 32'h7);
      wr(5'h00, 32'h0);
      wr(5'h10, 32'hFFFF);
      for (int i = 0; i < 8; i++) begin
         if (ata_cs_n != 2'b11 || !ata_diow_n || !ata_dior_n) act_cycles++;
         @(negedge clk);
      end
      check("R7 no cycle when disabled", act_cycles, 0);
      rd(5'h03, v); check("R7 not busy", v, 32'd0);
      rd(5'h04, v); check("R7 no error bit", v, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      wr(5'h00, 32'h1);
      wr(5'h02, 32'h01032);
      t_write();
      t_timing();
      t_read();
      t_reject();
      t_irq();
      t_iordy();
      t_swap();
      t_disable();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1-all actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule